// File: doc/BRIEF.md
# Instruction Fetch Cache with Refill Fault Invalidation

This block sits between the instruction fetch port of a processor and a slower downstream memory bus. It holds recently fetched instruction words in a read-only, set-associative store and answers repeated fetches without touching the bus. Line size in bytes, total line count and number of ways are parameters, each a power of two. The line size is at least 4 bytes. The set count is the line count divided by the ways.

A fetch that misses triggers a refill of the whole line that contains it, one 32-bit word at a time in ascending address order. The cache returns the requested word once the line is complete. If any word of a refill comes back with an error, or gets no answer within a bounded number of cycles, the refill stops. The line is then left invalid, so bad data is never cached, and the fetch ends with an error response. A flush input invalidates every line, which forces all later fetches to reload from memory. Among ways, the victim of a refill is the least recently used one, and way 0 is the first victim after reset.

Top module: `fetch_icache`

## Requirements
- R1: A fetch that hits gives `cpu_rsp_valid_o` with the correct word in the cycle right after the request is accepted, and issues no bus request.
- R2: A miss issues exactly LINE_BYTES/4 single-word bus requests, at byte addresses line_base, line_base+4, and so on in ascending order, where line_base is the fetch address with its low log2(LINE_BYTES) bits cleared. Each request is a one-cycle pulse. The fetch then completes with `cpu_rsp_valid_o` and the word at the fetch address. With an answer latency of L cycles the response comes 2 + (LINE_BYTES/4)*(2+L) cycles after acceptance.
- R3: After a successful refill, any fetch to a word of that line hits while the line stays resident.
- R4: With more than one way, the refill victim is the least recently used way of the set. After reset, way 0 is chosen first.
- R5: If a refill word returns `mem_err_i`, no further words of that line are requested. The fetch completes with `cpu_rsp_err_o` and without `cpu_rsp_valid_o`, and the next fetch to that line misses.
- R6: If a refill word gets no `mem_ack_i` or `mem_err_i` within TIMEOUT_CYC cycles, the refill is treated as a bus error, as in R5. For a first-word timeout the error response comes TIMEOUT_CYC+3 cycles after acceptance.
- R7: A one-cycle pulse on `flush_i` invalidates every line, so the next fetch to any previously cached line misses.
- R8: `cpu_ready_o` is low while a lookup, a refill or a flush is in progress, and also in any cycle where `flush_i` is high.
- R9: After reset `cpu_ready_o` is high, no response is signalled, no bus request is issued, and all lines are invalid.
- R10: `cpu_rsp_valid_o` and `cpu_rsp_err_o` are never high together, and each response lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 1 | Fetch request, accepted in a cycle where `cpu_ready_o` is high |
| cpu_addr_i | input | ADDR_W | Byte address of the fetch |
| cpu_ready_o | output | 1 | Cache can accept a fetch this cycle |
| cpu_rsp_valid_o | output | 1 | One-cycle pulse: fetch data is valid |
| cpu_rsp_err_o | output | 1 | One-cycle pulse: fetch failed with a bus error |
| cpu_rsp_data_o | output | 32 | Instruction word |
| flush_i | input | 1 | Invalidate all lines |
| mem_req_o | output | 1 | One-cycle pulse requesting one word from the bus |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rdata_i | input | 32 | Read data from the bus |
| mem_ack_i | input | 1 | Bus word delivered |
| mem_err_i | input | 1 | Bus word failed |

## Verification
A hit is due exactly one cycle after acceptance. A clean miss is due 2 + words*(2+L) cycles after acceptance, where L is the latency the bench memory applies. A first-word timeout is due TIMEOUT_CYC+3 cycles after acceptance. The bench drives and samples on the falling edge. It counts the falling edges from acceptance to the response and compares that count with these closed forms. Hit or miss is decided by a least-recently-used reference model in the bench, and its prediction is confirmed by counting the bus requests seen in each fetch window. The ready-low check for a flush falls on the single falling edge inside the flush cycle.

// File: rtl/fetch_icache_pkg.sv
package fetch_icache_pkg;

    localparam int XLEN       = 32;
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_DONE,
        ST_FLUSH
    } fill_state_e;

    typedef struct packed {
        logic            ok;
        logic            fault;
        logic [XLEN-1:0] word;
    } fetch_rsp_t;

    function automatic int width_of(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/fetch_icache_tags.sv
module fetch_icache_tags #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int TAG_W = 26,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o,
    output logic [WAY_W-1:0] hit_way_o,
    output logic [WAY_W-1:0] victim_o,
    input  logic             flush_all_i,
    input  logic             inv_i,
    input  logic             val_i,
    input  logic             touch_i,
    input  logic [WAY_W-1:0] way_i
);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAY_W-1:0] age_q   [SETS][WAYS];
    logic [WAYS-1:0]  way_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    end

    assign hit_o = |way_match;

    // Oldest way carries age WAYS-1; ages in a set are a permutation.
    always_comb begin
        hit_way_o = '0;
        victim_o  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w])
                hit_way_o = WAY_W'(w);
            if (age_q[set_i][w] == WAY_W'(WAYS - 1))
                victim_o = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
            end
        end else begin
            if (flush_all_i) begin
                for (int s = 0; s < SETS; s++)
                    valid_q[s] <= '0;
            end else begin
                if (inv_i)
                    valid_q[set_i][way_i] <= 1'b0;
                if (val_i)
                    valid_q[set_i][way_i] <= 1'b1;
            end
            if (touch_i) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == way_i)
                        age_q[set_i][w] <= '0;
                    else if (age_q[set_i][w] < age_q[set_i][way_i])
                        age_q[set_i][w] <= age_q[set_i][w] + WAY_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (val_i)
            tag_q[set_i][way_i] <= tag_i;
    end

endmodule

// File: rtl/fetch_icache_data.sv
module fetch_icache_data #(
    parameter int WAYS   = 2,
    parameter int SETS   = 4,
    parameter int WORDS  = 4,
    parameter int SET_W  = 2,
    parameter int WAY_W  = 1,
    parameter int WORD_W = 2
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  set_i,
    input  logic              wr_i,
    input  logic [WAY_W-1:0]  way_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  logic [31:0]       wr_data_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic [31:0]       rd_data_o
);

    localparam int DEPTH = SETS * WAYS * WORDS;
    localparam int IDX_W = fetch_icache_pkg::width_of(DEPTH);

    logic [31:0] store_q [DEPTH];

    function automatic logic [IDX_W-1:0] slot(input logic [SET_W-1:0] s,
                                              input logic [WAY_W-1:0] w,
                                              input logic [WORD_W-1:0] k);
        return IDX_W'((int'(s) * WAYS + int'(w)) * WORDS + int'(k));
    endfunction

    always_ff @(posedge clk) begin
        if (wr_i)
            store_q[slot(set_i, way_i, wr_word_i)] <= wr_data_i;
    end

    assign rd_data_o = store_q[slot(set_i, way_i, rd_word_i)];

endmodule

// File: rtl/fetch_icache_ctrl.sv
module fetch_icache_ctrl
    import fetch_icache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 16,
    parameter int WORDS       = 4,
    parameter int WORD_W      = 2,
    parameter int WAY_W       = 1,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              flush_i,
    output logic              cpu_ready_o,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              hit_i,
    input  logic [WAY_W-1:0]  hit_way_i,
    input  logic [WAY_W-1:0]  victim_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    output logic [WAY_W-1:0]  way_o,
    output logic [WORD_W-1:0] fill_word_o,
    output logic              fill_wr_o,
    output logic              tag_inv_o,
    output logic              tag_val_o,
    output logic              tag_touch_o,
    output logic              flush_all_o,
    output logic              rsp_ok_o,
    output logic              rsp_fault_o
);

    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

    fill_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] cnt_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [WAY_W-1:0]  victim_q;
    logic              fault_q;
    logic              flush_pend_q;
    logic              last_word;
    logic              expired;

    assign last_word   = (cnt_q == WORD_W'(WORDS - 1));
    assign expired     = (tmr_q == TMR_W'(TIMEOUT_CYC - 1));
    assign cpu_ready_o = (state_q == ST_IDLE) && !flush_pend_q && !flush_i;
    assign req_addr_o  = addr_q;
    assign fill_word_o = cnt_q;
    assign mem_addr_o  = (addr_q & ~ADDR_W'(LINE_BYTES - 1)) | (ADDR_W'(cnt_q) << 2);

    always_comb begin
        way_o       = victim_q;
        mem_req_o   = 1'b0;
        fill_wr_o   = 1'b0;
        tag_inv_o   = 1'b0;
        tag_val_o   = 1'b0;
        tag_touch_o = 1'b0;
        flush_all_o = 1'b0;
        rsp_ok_o    = 1'b0;
        rsp_fault_o = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                way_o = hit_i ? hit_way_i : victim_i;
                if (hit_i) begin
                    rsp_ok_o    = 1'b1;
                    tag_touch_o = 1'b1;
                end else begin
                    tag_inv_o = 1'b1;
                end
            end
            ST_FILL_REQ:  mem_req_o = 1'b1;
            ST_FILL_WAIT: fill_wr_o = mem_ack_i && !mem_err_i;
            ST_DONE: begin
                if (fault_q) begin
                    rsp_fault_o = 1'b1;
                end else begin
                    rsp_ok_o    = 1'b1;
                    tag_val_o   = 1'b1;
                    tag_touch_o = 1'b1;
                end
            end
            ST_FLUSH: flush_all_o = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            flush_pend_q <= 1'b0;
        else if (state_q == ST_IDLE)
            flush_pend_q <= 1'b0;
        else
            flush_pend_q <= flush_pend_q | flush_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            cnt_q    <= '0;
            tmr_q    <= '0;
            victim_q <= '0;
            fault_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (flush_pend_q || flush_i) begin
                        state_q <= ST_FLUSH;
                    end else if (cpu_req_i) begin
                        addr_q  <= cpu_addr_i;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit_i) begin
                        state_q <= ST_IDLE;
                    end else begin
                        victim_q <= victim_i;
                        cnt_q    <= '0;
                        fault_q  <= 1'b0;
                        state_q  <= ST_FILL_REQ;
                    end
                end
                ST_FILL_REQ: begin
                    tmr_q   <= '0;
                    state_q <= ST_FILL_WAIT;
                end
                ST_FILL_WAIT: begin
                    if (mem_err_i || (!mem_ack_i && expired)) begin
                        fault_q <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (mem_ack_i) begin
                        if (last_word) begin
                            state_q <= ST_DONE;
                        end else begin
                            cnt_q   <= cnt_q + WORD_W'(1);
                            state_q <= ST_FILL_REQ;
                        end
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                ST_FLUSH: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fetch_icache.sv
module fetch_icache
    import fetch_icache_pkg::*;
#(
    parameter int LINE_BYTES  = 16,
    parameter int LINE_COUNT  = 8,
    parameter int WAYS        = 2,
    parameter int ADDR_W      = 32,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    output logic              cpu_ready_o,
    output logic              cpu_rsp_valid_o,
    output logic              cpu_rsp_err_o,
    output logic [31:0]       cpu_rsp_data_o,
    input  logic              flush_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic              mem_err_i
);

    localparam int WORDS   = LINE_BYTES / WORD_BYTES;
    localparam int SETS    = LINE_COUNT / WAYS;
    localparam int WORD_LG = $clog2(WORDS);
    localparam int SET_LG  = $clog2(SETS);
    localparam int WORD_W  = width_of(WORDS);
    localparam int SET_W   = width_of(SETS);
    localparam int WAY_W   = width_of(WAYS);
    localparam int TAG_W   = ADDR_W - 2 - WORD_LG - SET_LG;

    logic [ADDR_W-1:0] req_addr;
    logic [WORD_W-1:0] word_sel;
    logic [SET_W-1:0]  set_sel;
    logic [TAG_W-1:0]  tag_sel;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic [WAY_W-1:0]  act_way;
    logic [WORD_W-1:0] fill_word;
    logic              fill_wr;
    logic              tag_inv;
    logic              tag_val;
    logic              tag_touch;
    logic              flush_all;
    logic [31:0]       rd_word;
    fetch_rsp_t        rsp;

    assign word_sel = WORD_W'((req_addr >> 2) & ADDR_W'(WORDS - 1));
    assign set_sel  = SET_W'((req_addr >> (2 + WORD_LG)) & ADDR_W'(SETS - 1));
    assign tag_sel  = TAG_W'(req_addr >> (2 + WORD_LG + SET_LG));

    fetch_icache_ctrl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORDS(WORDS),
        .WORD_W(WORD_W), .WAY_W(WAY_W), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i), .flush_i(flush_i),
        .cpu_ready_o(cpu_ready_o), .req_addr_o(req_addr),
        .hit_i(hit), .hit_way_i(hit_way), .victim_i(victim),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
        .way_o(act_way), .fill_word_o(fill_word), .fill_wr_o(fill_wr),
        .tag_inv_o(tag_inv), .tag_val_o(tag_val), .tag_touch_o(tag_touch),
        .flush_all_o(flush_all), .rsp_ok_o(rsp.ok), .rsp_fault_o(rsp.fault)
    );

    fetch_icache_tags #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst(rst),
        .set_i(set_sel), .tag_i(tag_sel),
        .hit_o(hit), .hit_way_o(hit_way), .victim_o(victim),
        .flush_all_i(flush_all), .inv_i(tag_inv), .val_i(tag_val),
        .touch_i(tag_touch), .way_i(act_way)
    );

    fetch_icache_data #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS),
        .SET_W(SET_W), .WAY_W(WAY_W), .WORD_W(WORD_W)
    ) u_data (
        .clk(clk), .set_i(set_sel),
        .wr_i(fill_wr), .way_i(act_way), .wr_word_i(fill_word), .wr_data_i(mem_rdata_i),
        .rd_word_i(word_sel), .rd_data_o(rd_word)
    );

    assign rsp.word        = rd_word;
    assign cpu_rsp_valid_o = rsp.ok;
    assign cpu_rsp_err_o   = rsp.fault;
    assign cpu_rsp_data_o  = rsp.word;

endmodule

// File: rtl/fetch_icache_chk.sv
module fetch_icache_chk #(
    parameter int ADDR_W      = 32,
    parameter int TIMEOUT_CYC = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_i,
    input logic              cpu_ready_o,
    input logic              cpu_rsp_valid_o,
    input logic              cpu_rsp_err_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ack_i,
    input logic              mem_err_i
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 2) + 1;

    logic             outstanding_q;
    logic [CNT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
            wait_q        <= '0;
        end else if (mem_req_o) begin
            outstanding_q <= 1'b1;
            wait_q        <= '0;
        end else if (outstanding_q) begin
            if (mem_ack_i || mem_err_i || cpu_rsp_err_o)
                outstanding_q <= 1'b0;
            else
                wait_q <= wait_q + CNT_W'(1);
        end
    end

    // R10
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rsp_valid_o && cpu_rsp_err_o));

    // R10
    rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rsp_valid_o || cpu_rsp_err_o) |=> !(cpu_rsp_valid_o || cpu_rsp_err_o));

    // R8
    busy_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> !cpu_ready_o);

    // R2
    word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);

    // R1
    lookup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_i && cpu_ready_o) |=> !mem_req_o);

    // R6
    fill_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        outstanding_q |-> (wait_q <= CNT_W'(TIMEOUT_CYC)));

endmodule

bind fetch_icache fetch_icache_chk #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst(rst), .cpu_req_i(cpu_req_i), .cpu_ready_o(cpu_ready_o),
    .cpu_rsp_valid_o(cpu_rsp_valid_o), .cpu_rsp_err_o(cpu_rsp_err_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i)
);

// File: tb/fetch_icache_tb.sv
module fetch_icache_tb;

    localparam int LINE_BYTES  = 16;
    localparam int LINE_COUNT  = 8;
    localparam int WAYS        = 2;
    localparam int ADDR_W      = 32;
    localparam int TIMEOUT_CYC = 64;
    localparam int WORDS       = LINE_BYTES / 4;
    localparam int SETS        = LINE_COUNT / WAYS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req_i = 1'b0;
    logic [ADDR_W-1:0] cpu_addr_i = '0;
    logic              cpu_ready_o, cpu_rsp_valid_o, cpu_rsp_err_o;
    logic [31:0]       cpu_rsp_data_o;
    logic              flush_i = 1'b0;
    logic              mem_req_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [31:0]       mem_rdata_i = '0;
    logic              mem_ack_i = 1'b0;
    logic              mem_err_i = 1'b0;

    fetch_icache #(
        .LINE_BYTES(LINE_BYTES), .LINE_COUNT(LINE_COUNT), .WAYS(WAYS),
        .ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_dut (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // memory model
    int          mem_lat = 0;
    bit          err_on = 0;
    bit          mute_on = 0;
    logic [31:0] err_addr = '0;
    bit          pend = 0;
    int          cd = 0;
    logic [31:0] paddr = '0;
    int          req_cnt = 0;
    logic [31:0] req_log [16];

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_ABCD;
    endfunction

    always @(negedge clk) begin
        mem_ack_i = 1'b0;
        mem_err_i = 1'b0;
        if (pend) begin
            if (cd == 0) begin
                if (err_on && paddr == err_addr) mem_err_i = 1'b1;
                else begin
                    mem_ack_i   = 1'b1;
                    mem_rdata_i = memfn(paddr);
                end
                pend = 0;
            end else cd--;
        end
        if (mem_req_o) begin
            if (req_cnt < 16) req_log[req_cnt] = mem_addr_o;
            req_cnt++;
            if (!mute_on) begin
                pend  = 1;
                paddr = mem_addr_o;
                cd    = mem_lat;
            end
        end
    end

    // reference model of residency and LRU order
    logic [31:0] m_line [SETS][WAYS];
    bit          m_val  [SETS][WAYS];
    int          m_use  [SETS][WAYS];
    int          tick = WAYS;

    function automatic int set_of(input logic [31:0] a);
        return int'((a / LINE_BYTES) % SETS);
    endfunction

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, output bit ok, output bit er,
                            output logic [31:0] d, output int lat, output bit busy_bad);
        busy_bad = 0;
        while (!cpu_ready_o) @(negedge clk);
        req_cnt   = 0;
        cpu_req_i = 1'b1;
        cpu_addr_i = a;
        @(negedge clk);
        cpu_req_i = 1'b0;
        lat = 1;
        while (!(cpu_rsp_valid_o || cpu_rsp_err_o) && lat < 1000) begin
            if (cpu_ready_o) busy_bad = 1;
            @(negedge clk);
            lat++;
        end
        if (cpu_ready_o) busy_bad = 1;
        ok = cpu_rsp_valid_o;
        er = cpu_rsp_err_o;
        d  = cpu_rsp_data_o;
    endtask

    task automatic fetch_chk(input logic [31:0] a, input string tagname);
        int s = set_of(a);
        logic [31:0] base = a & ~32'(LINE_BYTES - 1);
        int hw = -1;
        int v = 0;
        bit ok, er, busy_bad, fault_exp;
        logic [31:0] d;
        int lat;
        for (int w = 0; w < WAYS; w++)
            if (m_val[s][w] && m_line[s][w] == base) hw = w;
        for (int w = 1; w < WAYS; w++)
            if (m_use[s][w] < m_use[s][v]) v = w;
        fault_exp = mute_on || (err_on && (err_addr & ~32'(LINE_BYTES - 1)) == base);
        do_fetch(a, ok, er, d, lat, busy_bad);
        if (hw >= 0) begin
            // R1 / R3 hit
            chk(ok && !er && d == memfn(a), {"R1 R3 ", tagname}, "hit data", d, memfn(a));
            chk(lat == 1 && req_cnt == 0, {"R1 ", tagname}, "hit latency/bus", 32'(lat), 32'd1);
            m_use[s][hw] = ++tick;
        end else if (fault_exp) begin
            // R5 / R6 error path
            chk(er && !ok, {"R5 ", tagname}, "fault response", {30'd0, ok, er}, 32'd1);
            if (mute_on)
                chk(lat == TIMEOUT_CYC + 3, {"R6 ", tagname}, "timeout latency",
                    32'(lat), 32'(TIMEOUT_CYC + 3));
            m_val[s][v] = 0;
        end else begin
            // R2 miss refill
            chk(ok && !er && d == memfn(a), {"R2 ", tagname}, "miss data", d, memfn(a));
            chk(req_cnt == WORDS, {"R2 ", tagname}, "word requests", 32'(req_cnt), 32'(WORDS));
            for (int i = 0; i < WORDS && i < 16; i++)
                if (req_log[i] != base + 32'(4 * i))
                    chk(0, {"R2 ", tagname}, "request order", req_log[i], base + 32'(4 * i));
            chk(lat == 2 + WORDS * (2 + mem_lat), {"R2 ", tagname}, "miss latency",
                32'(lat), 32'(2 + WORDS * (2 + mem_lat)));
            m_val[s][v]  = 1;
            m_line[s][v] = base;
            m_use[s][v]  = ++tick;
        end
        // R8
        chk(!busy_bad, {"R8 ", tagname}, "ready while busy", 32'(busy_bad), 32'd0);
    endtask

    task automatic do_flush(input string tagname);
        while (!cpu_ready_o) @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        chk(!cpu_ready_o, {"R8 ", tagname}, "ready during flush", 32'(cpu_ready_o), 32'd0);
        @(negedge clk);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                m_val[s][w] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0;
                m_use[s][w] = w;
                m_line[s][w] = '0;
            end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(cpu_ready_o && !cpu_rsp_valid_o && !cpu_rsp_err_o && !mem_req_o, "R9",
            "reset outputs", {28'd0, cpu_ready_o, cpu_rsp_valid_o, cpu_rsp_err_o, mem_req_o},
            32'h8);

        // R9 / R2: first fetch misses, full line refill
        fetch_chk(32'h104, "cold miss R9");
        // R3 other words of the line hit
        fetch_chk(32'h108, "same line R3");
        fetch_chk(32'h10C, "same line R3");

        // R4 LRU in set 0
        mem_lat = 1;
        fetch_chk(32'h140, "second way R4");
        fetch_chk(32'h100, "first way kept R4");
        fetch_chk(32'h180, "evicts LRU R4");
        fetch_chk(32'h104, "MRU resident R4");
        fetch_chk(32'h148, "LRU evicted R4");

        // R5 error on third word
        mem_lat  = 0;
        err_on   = 1;
        err_addr = 32'h208;
        fetch_chk(32'h200, "bus error R5");
        chk(req_cnt == 3, "R5", "requests stop at error", 32'(req_cnt), 32'd3);
        err_on = 0;
        fetch_chk(32'h204, "refetch after error R5");

        // R6 timeout
        mute_on = 1;
        fetch_chk(32'h310, "timeout R6");
        mute_on = 0;
        fetch_chk(32'h310, "refetch after timeout R6");

        // R7 flush
        fetch_chk(32'h104, "before flush R7");
        do_flush("flush R7");
        fetch_chk(32'h104, "after flush R7");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int r = int'($urandom % 100);
            if (r < 4) do_flush("random flush R7");
            else begin
                mem_lat = int'($urandom % 3);
                fetch_chk(32'(($urandom % 96) * 4), "random R1 R2 R3 R4");
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule